// File: doc/BRIEF.md
# Serial Baud Rate Generator

This block produces the timing strobes for one channel of a serial communication interface. A host-writable 8-bit divisor N and a 2-bit prescale select n set the rate. The system clock first passes through a prescaler that divides by 1, 4, 16 or 64 (4 to the power n). A down-counter then divides by N+1, so one rate tick occurs every 4^n·(N+1) system clocks.

In asynchronous mode the block emits a one-cycle sampling strobe on every second rate tick. It also emits a bit-boundary pulse every 32 rate ticks, or every 16 rate ticks when the double-speed flag is set. In clocked synchronous mode it drives a serial clock that idles high and toggles every second rate tick, so one serial clock period (4 rate ticks) is one bit. In that mode the bit-boundary pulse marks each rising edge and the double-speed flag has no effect.

A write to either rate register restarts the counting, so the new rate applies cleanly. Each channel uses its own instance, so each can run at its own rate.

Top module: `baud_gen`

## Requirements
- R1: After reset the divisor reads 0xFF, the prescale select reads 0, the sampling strobe and bit pulse are low and the serial clock is high.
- R2: A divisor or prescale-select write is visible on the readback ports in the cycle after the write, whatever the state of the enable and mode inputs.
- R3: Prescale select 0, 1, 2 and 3 divide by 1, 4, 16 and 64. Rate tick m (counting from 1) falls on cycle m·4^n·(N+1)−1 after the last restart, where cycle 0 is the first cycle after the restart.
- R4: In asynchronous mode (syncMode=0) with doubleSpeed=0, the sampling strobe is a single-cycle pulse in the cycle after each even-numbered rate tick. The bit pulse rises with the strobe after every 32nd rate tick, which gives 16 strobes per bit.
- R5: In asynchronous mode with doubleSpeed=1, the strobe timing is the same as in R4. The bit pulse follows every 16th rate tick, which gives 8 strobes per bit.
- R6: In synchronous mode (syncMode=1) the sampling strobe stays low. The serial clock falls after rate ticks 2, 6, 10 and so on, and rises after rate ticks 4, 8 and so on. The bit pulse coincides with each rise, and doubleSpeed has no effect.
- R7: A write to the divisor or the prescale select clears the prescaler, the divider and the tick phase, and timing restarts from the cycle after the write.
- R8: While enable is low the counters are held cleared, the strobe and bit pulse are low and the serial clock is high. Raising enable restarts timing as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low holds the generator idle |
| syncMode | input | 1 | 1 = clocked synchronous, 0 = asynchronous |
| doubleSpeed | input | 1 | Asynchronous double-speed select |
| divWrEn | input | 1 | Divisor write strobe |
| divWrData | input | 8 | Divisor write value N |
| selWrEn | input | 1 | Prescale-select write strobe |
| selWrData | input | 2 | Prescale-select write value n |
| divRdData | output | 8 | Divisor readback |
| selRdData | output | 2 | Prescale-select readback |
| sampleStrobe | output | 1 | Asynchronous sampling strobe, one cycle wide |
| serialClk | output | 1 | Synchronous serial clock, idles high |
| bitStrobe | output | 1 | One-cycle pulse at each bit boundary |

## Verification
The rate state in this block is invisible except through the spacing of its output pulses. A wrong prescaler limit or divider reload shows at the ports as a misplaced sampling strobe or serial clock edge. That error appears no later than the second rate tick after a restart, which is at most 2·4^n·(N+1) clocks. A phase counter that slips shows up in the bit pulse within one bit period, and in synchronous mode as a serial clock edge on the wrong tick. A restart that fails to clear the counters shifts the first strobe after a register write, so the bench compares every output on every clock against a cycle-count model.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;        // restart all counters this cycle
    logic syncMode;     // clocked synchronous operation
    logic doubleSpeed;  // asynchronous double-speed sampling
  } rateCtrl_t;

endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             syncMode,
  input  logic             doubleSpeed,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  output logic [DIV_W-1:0] divReg,
  output logic [SEL_W-1:0] selReg,
  output logic [DIV_W-1:0] divLoad,
  output rateCtrl_t        ctrl
);

  // Host-visible rate registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= '1;
      selReg <= '0;
    end else begin
      if (divWrEn) divReg <= divWrData;
      if (selWrEn) selReg <= selWrData;
    end
  end

  // Reload value for the divider on a restart: the value that becomes current.
  always_comb begin
    divLoad = divWrEn ? divWrData : divReg;
  end

  always_comb begin
    ctrl.clear       = divWrEn || selWrEn || !enable;
    ctrl.syncMode    = syncMode;
    ctrl.doubleSpeed = doubleSpeed;
  end

  // R2: a write lands in the register one cycle later
  a_r2_div_write: assert property (@(posedge clk) disable iff (!rstN)
    divWrEn |=> divReg == $past(divWrData));
  a_r2_sel_write: assert property (@(posedge clk) disable iff (!rstN)
    selWrEn |=> selReg == $past(selWrData));
  // R2: without a write the registers keep their values
  a_r2_div_hold: assert property (@(posedge clk) disable iff (!rstN)
    !divWrEn |=> $stable(divReg));

endmodule

// File: rtl/baud_gen_datapath.sv
module baud_gen_datapath
  import baud_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int SEL_W   = 2,
  parameter int PHASE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  rateCtrl_t        ctrl,
  input  logic [DIV_W-1:0] divVal,
  input  logic [DIV_W-1:0] divLoad,
  input  logic [SEL_W-1:0] selVal,
  output logic             sampleStrobe,
  output logic             serialClk,
  output logic             bitStrobe
);

  // Prescaler width covers the largest ratio 4^(2^SEL_W - 1).
  localparam int PRE_W    = 2 * ((1 << SEL_W) - 1);
  localparam int SEL_CNT  = 1 << SEL_W;
  localparam int SYNC_W   = 2;  // four rate ticks per serial clock period

  // ---------------- prescaler ----------------
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             baseTick;

  // Limit is 4^n - 1, picked from a table built per select value.
  logic [PRE_W-1:0] limitTab [SEL_CNT];
  for (genvar g = 0; g < SEL_CNT; g++) begin : g_limit
    assign limitTab[g] = PRE_W'((64'd1 << (2 * g)) - 64'd1);
  end

  always_comb begin
    preLimit = limitTab[selVal];
  end

  always_comb begin
    baseTick = !ctrl.clear && (preCnt == preLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      preCnt <= '0;
    end else if (baseTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // ---------------- (N+1) divider ----------------
  logic [DIV_W-1:0] divCnt;
  logic             rateTick;

  always_comb begin
    rateTick = baseTick && (divCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '1;
    end else if (ctrl.clear) begin
      divCnt <= divLoad;
    end else if (baseTick) begin
      if (divCnt == '0) divCnt <= divVal;
      else              divCnt <= divCnt - 1'b1;
    end
  end

  // ---------------- tick phase and outputs ----------------
  logic [PHASE_W-1:0] phase;
  logic               evenTick;
  logic               bitHit;

  always_comb begin
    evenTick = rateTick && phase[0];
    if (ctrl.syncMode) begin
      bitHit = (phase[SYNC_W-1:0] == '1);
    end else if (ctrl.doubleSpeed) begin
      bitHit = (phase[PHASE_W-2:0] == '1);
    end else begin
      bitHit = (phase == '1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      phase <= '0;
    end else if (rateTick) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      sampleStrobe <= 1'b0;
      serialClk    <= 1'b1;
      bitStrobe    <= 1'b0;
    end else begin
      sampleStrobe <= evenTick && !ctrl.syncMode;
      bitStrobe    <= rateTick && bitHit;
      if (!ctrl.syncMode) begin
        serialClk <= 1'b1;
      end else if (evenTick) begin
        serialClk <= !serialClk;
      end
    end
  end

  // R3: prescaler never passes its limit, divider never passes N
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimit);
  a_r3_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divVal);
  // R4: the sampling strobe is one cycle wide
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);
  // R4/R6: a bit boundary coincides with a strobe or a serial clock high
  a_r4_bit_aligned: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> (sampleStrobe || serialClk));
  // R6: no sampling strobe in synchronous mode
  a_r6_no_strobe_sync: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.syncMode |=> !sampleStrobe);
  // R8: a restart leaves outputs idle
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (!sampleStrobe && serialClk && !bitStrobe));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int SEL_W   = 2,
  parameter int PHASE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             syncMode,
  input  logic             doubleSpeed,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  output logic [DIV_W-1:0] divRdData,
  output logic [SEL_W-1:0] selRdData,
  output logic             sampleStrobe,
  output logic             serialClk,
  output logic             bitStrobe
);

  rateCtrl_t        ctrl;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divLoad;
  logic [SEL_W-1:0] selReg;

  baud_gen_ctrl #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .syncMode    (syncMode),
    .doubleSpeed (doubleSpeed),
    .divWrEn     (divWrEn),
    .divWrData   (divWrData),
    .selWrEn     (selWrEn),
    .selWrData   (selWrData),
    .divReg      (divReg),
    .selReg      (selReg),
    .divLoad     (divLoad),
    .ctrl        (ctrl)
  );

  baud_gen_datapath #(.DIV_W(DIV_W), .SEL_W(SEL_W), .PHASE_W(PHASE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .divVal       (divReg),
    .divLoad      (divLoad),
    .selVal       (selReg),
    .sampleStrobe (sampleStrobe),
    .serialClk    (serialClk),
    .bitStrobe    (bitStrobe)
  );

  assign divRdData = divReg;
  assign selRdData = selReg;

endmodule

// File: tb/baud_gen_bench.sv
`timescale 1ns/1ps
module baud_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       syncMode = 1'b0;
  logic       doubleSpeed = 1'b0;
  logic       divWrEn = 1'b0;
  logic [7:0] divWrData = '0;
  logic       selWrEn = 1'b0;
  logic [1:0] selWrData = '0;
  logic [7:0] divRdData;
  logic [1:0] selRdData;
  logic       sampleStrobe, serialClk, bitStrobe;

  always #2.5 clk = ~clk;  // 200 MHz

  baud_gen u_baud_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .syncMode(syncMode),
    .doubleSpeed(doubleSpeed), .divWrEn(divWrEn), .divWrData(divWrData),
    .selWrEn(selWrEn), .selWrData(selWrData), .divRdData(divRdData),
    .selRdData(selRdData), .sampleStrobe(sampleStrobe),
    .serialClk(serialClk), .bitStrobe(bitStrobe)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string curReq = "R1";
  bit    done   = 0;

  // Behavioural model: cycles since the last restart and tick arithmetic.
  int mdlN = 255, mdlSel = 0, k = 0;
  bit expStrobe = 0, expSclk = 1, expBit = 0;
  int strobeSeen = 0, bitSeen = 0, fallSeen = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int t, m;
    bit tick, clr;
    #1;
    cycles++;
    if (!rstN) begin
      mdlN = 255; mdlSel = 0; k = 0;
      expStrobe = 0; expSclk = 1; expBit = 0;
    end else begin
      clr = divWrEn || selWrEn || !enable;
      if (clr) begin
        if (divWrEn) mdlN = divWrData;
        if (selWrEn) mdlSel = selWrData;
        k = 0; expStrobe = 0; expSclk = 1; expBit = 0;
      end else begin
        t = (4 ** mdlSel) * (mdlN + 1);
        tick = ((k + 1) % t) == 0;
        m = (k + 1) / t;
        expStrobe = !syncMode && tick && (m % 2 == 0);
        if (!syncMode) expSclk = 1;
        else if (tick && (m % 2 == 0)) expSclk = !expSclk;
        expBit = tick && (syncMode ? (m % 4 == 0)
                                   : (doubleSpeed ? (m % 16 == 0) : (m % 32 == 0)));
        k++;
      end
    end
    if (rstN && !done) begin
      check(curReq, "sampleStrobe", sampleStrobe, expStrobe);
      check(curReq, "serialClk", serialClk, expSclk);
      check(curReq, "bitStrobe", bitStrobe, expBit);
      check("R2", "divRdData", divRdData, mdlN);
      check("R2", "selRdData", selRdData, mdlSel);
      strobeSeen += sampleStrobe;
      bitSeen    += bitStrobe;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeDiv(logic [7:0] v);
    @(negedge clk); divWrEn = 1; divWrData = v;
    @(negedge clk); divWrEn = 0;
  endtask

  task automatic writeSel(logic [1:0] v);
    @(negedge clk); selWrEn = 1; selWrData = v;
    @(negedge clk); selWrEn = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset values at the ports
    curReq = "R1";
    check("R1", "reset divisor", divRdData, 255);
    check("R1", "reset select", selRdData, 0);
    check("R1", "reset sclk", serialClk, 1);
    check("R1", "reset strobe", sampleStrobe, 0);
    enable = 1;
    idle(600);  // default N=255, n=0: first strobe at cycle 512

    // R3: each prescale select
    curReq = "R3";
    writeDiv(8'd2); writeSel(2'd1); idle(900);
    writeDiv(8'd1); writeSel(2'd2); idle(1300);
    writeDiv(8'd0); writeSel(2'd3); idle(2600);
    writeSel(2'd0); idle(200);

    // R4: normal asynchronous, N=3, n=0: bit every 128 cycles
    curReq = "R4";
    strobeSeen = 0; bitSeen = 0;
    writeDiv(8'd3); idle(640);
    check("R4", "strobes per 5 bits", strobeSeen, 80);
    check("R4", "bits seen", bitSeen, 5);

    // R5: double speed
    curReq = "R5";
    doubleSpeed = 1;
    strobeSeen = 0; bitSeen = 0;
    writeDiv(8'd3); idle(640);
    check("R5", "strobes", strobeSeen, 80);
    check("R5", "bits seen", bitSeen, 10);

    // R6: synchronous, doubleSpeed both ways
    curReq = "R6";
    syncMode = 1;
    strobeSeen = 0; bitSeen = 0;
    writeDiv(8'd1); writeSel(2'd1); idle(320);
    check("R6", "no strobe in sync", strobeSeen, 0);
    check("R6", "sync bits ds=1", bitSeen, 10);
    doubleSpeed = 0; bitSeen = 0;
    writeSel(2'd1); idle(320);
    check("R6", "sync bits ds=0", bitSeen, 10);

    // R7: rewrite mid-period restarts timing
    curReq = "R7";
    syncMode = 0;
    writeDiv(8'd5); idle(17);
    writeDiv(8'd5); idle(30);
    writeSel(2'd1); idle(70);
    writeDiv(8'd9); idle(300);

    // R8: enable low holds idle, then restarts; R2 write while disabled
    curReq = "R8";
    idle(13);
    enable = 0; idle(40);
    curReq = "R2";
    writeDiv(8'd7); writeSel(2'd0);
    check("R2", "readback while disabled", divRdData, 7);
    curReq = "R8";
    idle(10);
    enable = 1; idle(200);
    syncMode = 1; writeDiv(8'd0); idle(9);
    enable = 0; idle(5); enable = 1; idle(60);

    idle(2);
    finishRun();
  end

endmodule